// File: doc/BRIEF.md
# Clock-Hand Victim Selector with Throttled Insertion

This block is the replacement engine of a 16-way set-associative cache. For every set it keeps one reference bit per way and a rotating hand that points at one way. Lookups that hit mark the hitting way as recently referenced. A miss starts a hand sweep over the addressed set. The sweep clears reference bits it passes and stops on the first way whose bit is already clear. That way is returned as the victim, and the incoming block is installed there.

When the block is installed, its reference bit is either set, which protects it for a while, or left clear, which makes it the next victim unless it is referenced again. The choice comes from a per-request insertion mode. Protective mode always sets the bit. Throttled mode sets it only while a wrapping miss counter is below a threshold L, so protected fills arrive in bursts. Hits that are really write-backs from the level above carry a flag and leave the state alone. Tag and data storage, and the choice of mode, belong to the surrounding cache.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every reference bit is clear, every hand is at way 0, miss_ready is 1 and victim_valid is 0. The first miss to any set therefore returns way 0 after one sweep cycle.
- R2: A hit with hit_wb=0 sets the reference bit of hit_way in hit_set and does not move that set's hand.
- R3: A hit with hit_wb=1 changes neither reference bits nor hands.
- R4: A sweep examines one way per cycle, starting at the hand. A set bit is cleared and the hand advances by one modulo 16. A clear bit ends the sweep. If k set bits are passed, victim_valid is high for exactly one cycle, k+1 clock edges after the accepting edge, with victim_way equal to the stopping way. This gives at most 17 sweep cycles.
- R5: miss_ready is 1 only while no sweep is running. miss_valid has no effect while miss_ready is 0.
- R6: After a fill the hand stays on the victim way, so the next sweep of that set starts there.
- R7: In protective mode (miss_bimodal=0) the filled way's reference bit is set.
- R8: A THR_W-bit counter advances by one, with wrap-around, on every accepted miss in either mode. In throttled mode (miss_bimodal=1) the filled way's bit is set only when the counter value at acceptance is below THR_L.
- R9: If a hit to the swept set lands in the same cycle as a sweep step, the step decides using the bit as it stood before that cycle, and the hit's set bit wins over the step's clear or fill.
- R10: Each set's hand and reference bits change only through requests addressed to that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A lookup hit is reported this cycle |
| hit_wb | input | 1 | The hit is a write-back from above; ignore it |
| hit_set | input | SET_W | Set of the hit |
| hit_way | input | WAY_W | Way that hit |
| miss_valid | input | 1 | Request a victim for a miss |
| miss_bimodal | input | 1 | 0 = protective fill, 1 = throttled fill |
| miss_set | input | SET_W | Set of the miss |
| miss_ready | output | 1 | Engine idle; a miss is accepted |
| victim_valid | output | 1 | One-cycle pulse with the chosen way |
| victim_way | output | WAY_W | Victim way, valid with victim_valid |

## Verification
A hit and a sweep step can touch the same set in the same cycle. If the hit falls on the way under the hand, both also write the same bit. The bench provokes this by issuing a throttled miss while the counter is at or above THR_L, then placing a hit on that set's hand way on the edge where the first sweep step happens. The returned victim must still be that way, because it was decided from the old bit. The next throttled miss on the set must then skip that way and take one extra cycle, which shows that the hit's set bit won over the unprotected fill.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

  typedef enum logic [0:0] {
    ENG_IDLE = 1'b0,
    ENG_SCAN = 1'b1
  } eng_state_e;

  // Protective fill decision for one accepted miss.
  function automatic logic fill_protect(input logic bimodal,
                                        input int unsigned cnt,
                                        input int unsigned limit);
    return (!bimodal) || (cnt < limit);
  endfunction

endpackage

// File: rtl/cvs_throttle.sv
module cvs_throttle #(
  parameter int CNT_W = 12,
  parameter int LIMIT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic             bimodal,
  output logic             protect_o,
  output logic [CNT_W-1:0] cnt_o
);
  import cvs_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (bump) cnt_q <= cnt_q + 1'b1;
  end

  assign protect_o = fill_protect(bimodal, 32'(cnt_q), LIMIT);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/cvs_use_store.sv
module cvs_use_store #(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 16,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_we,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic [SET_W-1:0] scan_set,
  input  logic             scan_skip,
  input  logic             scan_fill,
  input  logic             fill_bit,
  output logic [WAY_W-1:0] scan_hand,
  output logic             scan_bit
);
  logic [NUM_SETS-1:0][NUM_WAYS-1:0] use_q, use_d;
  logic [NUM_SETS-1:0][WAY_W-1:0]    hand_q, hand_d;

  function automatic logic [NUM_WAYS-1:0] next_use(
    input logic [NUM_WAYS-1:0] cur,
    input logic [WAY_W-1:0]    hand,
    input logic                skip,
    input logic                fill,
    input logic                fbit,
    input logic                hit,
    input logic [WAY_W-1:0]    hway);
    logic [NUM_WAYS-1:0] v;
    v = cur;
    if (skip)      v[hand] = 1'b0;
    else if (fill) v[hand] = fbit;
    if (hit)       v[hway] = 1'b1;
    return v;
  endfunction

  function automatic logic [WAY_W-1:0] next_hand(input logic [WAY_W-1:0] hand,
                                                 input logic skip);
    return skip ? WAY_W'(hand + 1'b1) : hand;
  endfunction

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic on_scan, on_hit;
    assign on_scan   = (scan_set == SET_W'(s));
    assign on_hit    = hit_we && (hit_set == SET_W'(s));
    assign use_d[s]  = next_use(use_q[s], hand_q[s], on_scan && scan_skip,
                                on_scan && scan_fill, fill_bit, on_hit, hit_way);
    assign hand_d[s] = next_hand(hand_q[s], on_scan && scan_skip);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_q  <= '0;
      hand_q <= '0;
    end else begin
      use_q  <= use_d;
      hand_q <= hand_d;
    end
  end

  assign scan_hand = hand_q[scan_set];
  assign scan_bit  = use_q[scan_set][scan_hand];
endmodule

// File: rtl/cvs_scan_ctrl.sv
module cvs_scan_ctrl #(
  parameter int SET_W = 6,
  parameter int WAY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic             miss_bimodal,
  input  logic [SET_W-1:0] miss_set,
  input  logic             protect_in,
  input  logic             exam_bit,
  input  logic [WAY_W-1:0] exam_hand,
  output logic             ready,
  output logic             accept,
  output logic [SET_W-1:0] scan_set,
  output logic             scan_skip,
  output logic             scan_found,
  output logic             fill_bit,
  output logic             fill_mode,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  import cvs_pkg::*;

  eng_state_e       state_q;
  logic [SET_W-1:0] set_q;
  logic             fill_q, mode_q, vv_q;
  logic [WAY_W-1:0] vw_q;
  logic             scanning;

  assign ready      = (state_q == ENG_IDLE);
  assign accept     = miss_valid && ready;
  assign scanning   = (state_q == ENG_SCAN);
  assign scan_skip  = scanning && exam_bit;
  assign scan_found = scanning && !exam_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      set_q   <= '0;
      fill_q  <= 1'b0;
      mode_q  <= 1'b0;
      vv_q    <= 1'b0;
      vw_q    <= '0;
    end else begin
      vv_q <= scan_found;
      if (accept) begin
        state_q <= ENG_SCAN;
        set_q   <= miss_set;
        fill_q  <= protect_in;
        mode_q  <= miss_bimodal;
      end else if (scan_found) begin
        state_q <= ENG_IDLE;
        vw_q    <= exam_hand;
      end
    end
  end

  assign scan_set     = set_q;
  assign fill_bit     = fill_q;
  assign fill_mode    = mode_q;
  assign victim_valid = vv_q;
  assign victim_way   = vw_q;
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 16,
  parameter int THR_L    = 64,
  parameter int THR_W    = 12,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_valid,
  input  logic             hit_wb,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             miss_valid,
  input  logic             miss_bimodal,
  input  logic [SET_W-1:0] miss_set,
  output logic             miss_ready,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  logic             hit_we, accept, protect, exam_bit;
  logic             scan_skip, scan_found, fill_bit, fill_mode;
  logic [SET_W-1:0] scan_set;
  logic [WAY_W-1:0] exam_hand;
  logic [THR_W-1:0] thr_cnt;

  assign hit_we = hit_valid && !hit_wb;

  cvs_throttle #(.CNT_W(THR_W), .LIMIT(THR_L)) u_thr (
    .clk(clk), .rst_n(rst_n), .bump(accept), .bimodal(miss_bimodal),
    .protect_o(protect), .cnt_o(thr_cnt));

  cvs_use_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_store (
    .clk(clk), .rst_n(rst_n), .hit_we(hit_we), .hit_set(hit_set),
    .hit_way(hit_way), .scan_set(scan_set), .scan_skip(scan_skip),
    .scan_fill(scan_found), .fill_bit(fill_bit), .scan_hand(exam_hand),
    .scan_bit(exam_bit));

  cvs_scan_ctrl #(.SET_W(SET_W), .WAY_W(WAY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid),
    .miss_bimodal(miss_bimodal), .miss_set(miss_set), .protect_in(protect),
    .exam_bit(exam_bit), .exam_hand(exam_hand), .ready(miss_ready),
    .accept(accept), .scan_set(scan_set), .scan_skip(scan_skip),
    .scan_found(scan_found), .fill_bit(fill_bit), .fill_mode(fill_mode),
    .victim_valid(victim_valid), .victim_way(victim_way));
endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
  parameter int NUM_WAYS = 16,
  parameter int THR_W    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic             victim_valid,
  input logic             scan_found,
  input logic             fill_bit,
  input logic             fill_mode,
  input logic [THR_W-1:0] thr_cnt
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)          busy_run <= 0;
    else if (miss_ready) busy_run <= 0;
    else                 busy_run <= busy_run + 1;
  end

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);

  a_r4_found_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    scan_found |=> victim_valid);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid);

  a_r4_bounded_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_ready |-> (busy_run <= NUM_WAYS));

  a_r7_protective_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_found && !fill_mode) |-> fill_bit);

  a_r8_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (thr_cnt == THR_W'($past(thr_cnt) + 1'b1)));
endmodule

bind clock_victim_sel cvs_checker #(.NUM_WAYS(NUM_WAYS), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .victim_valid(victim_valid), .scan_found(scan_found), .fill_bit(fill_bit),
  .fill_mode(fill_mode), .thr_cnt(thr_cnt));

// File: tb/clock_victim_sel_tb.sv
module clock_victim_sel_tb_top;
  localparam int NS = 4;
  localparam int NW = 16;
  localparam int TL = 2;
  localparam int TW = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hit_valid = 1'b0, hit_wb = 1'b0;
  logic [1:0] hit_set = '0;
  logic [3:0] hit_way = '0;
  logic       miss_valid = 1'b0, miss_bimodal = 1'b0;
  logic [1:0] miss_set = '0;
  logic       miss_ready, victim_valid;
  logic [3:0] victim_way;

  int checks = 0, fails = 0, cycles = 0;
  bit m_use [NS][NW];
  int m_hand [NS];
  int m_cnt = 0;
  int unsigned lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  clock_victim_sel #(.NUM_SETS(NS), .NUM_WAYS(NW), .THR_L(TL), .THR_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_wb(hit_wb),
    .hit_set(hit_set), .hit_way(hit_way), .miss_valid(miss_valid),
    .miss_bimodal(miss_bimodal), .miss_set(miss_set), .miss_ready(miss_ready),
    .victim_valid(victim_valid), .victim_way(victim_way));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_hit(input int s, input int w, input bit wb);
    @(negedge clk);
    hit_valid = 1'b1; hit_wb = wb; hit_set = 2'(s); hit_way = 4'(w);
    @(negedge clk);
    hit_valid = 1'b0; hit_wb = 1'b0;
    if (!wb) m_use[s][w] = 1'b1;
  endtask

  // mode: 0 plain, 1 collide a hit on the hand way, 2 poke while busy
  task automatic do_miss(input int s, input bit bim, input int mode, input string tag);
    int steps, exp_way, cyc;
    bit prot;
    prot = !bim || (m_cnt < TL);
    m_cnt = (m_cnt + 1) % (1 << TW);
    steps = 0;
    while (m_use[s][m_hand[s]]) begin
      m_use[s][m_hand[s]] = 1'b0;
      m_hand[s] = (m_hand[s] + 1) % NW;
      steps++;
    end
    exp_way = m_hand[s];
    m_use[s][exp_way] = prot;
    if (mode == 1) m_use[s][exp_way] = 1'b1;
    @(negedge clk);
    miss_valid = 1'b1; miss_bimodal = bim; miss_set = 2'(s);
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    if (mode == 1) begin
      hit_valid = 1'b1; hit_wb = 1'b0; hit_set = 2'(s); hit_way = 4'(exp_way);
    end
    if (mode == 2) begin
      check({tag, " R5 ready low"}, int'(miss_ready), 0);
      miss_valid = 1'b1; miss_set = 2'((s + 1) % NS);
    end
    cyc = 0;
    while (!victim_valid && cyc < 40) begin
      @(negedge clk);
      hit_valid = 1'b0;
      miss_valid = 1'b0;
      cyc++;
    end
    check({tag, " way"}, int'(victim_way), exp_way);
    check({tag, " latency"}, cyc, steps + 1);
    @(negedge clk);
    check({tag, " R4 pulse"}, int'(victim_valid), 0);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_hand[s] = 0;
      for (int w = 0; w < NW; w++) m_use[s][w] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", int'(miss_ready), 1);
    check("R1 valid", int'(victim_valid), 0);
    do_miss(0, 1'b0, 0, "R1 first miss set0");
    do_miss(1, 1'b0, 0, "R10 first miss set1");
    do_miss(2, 1'b1, 1, "R9 collide");
    do_miss(2, 1'b1, 0, "R9 hit bit kept");
    do_miss(2, 1'b1, 0, "R8 unprotected refill");
    do_hit(3, 0, 1'b1);
    do_miss(3, 1'b0, 0, "R3 wb ignored");
    do_hit(3, 1, 1'b0);
    do_miss(3, 1'b0, 0, "R2 R6 hit protects");
    for (int w = 0; w < NW; w++) do_hit(0, w, 1'b0);
    do_miss(0, 1'b0, 0, "R4 full sweep");
    do_miss(1, 1'b1, 2, "R5 busy poke");
    for (int i = 0; i < 500; i++) begin
      int op, s, w;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      op = int'((lcg >> 4) % 8);
      s  = int'((lcg >> 9) % NS);
      w  = int'((lcg >> 13) % NW);
      case (op)
        0, 1, 2: do_hit(s, w, 1'b0);
        3:       do_hit(s, w, 1'b1);
        4, 5:    do_miss(s, 1'b0, 0, "R7 sweep normal");
        default: do_miss(s, 1'b1, 0, "R8 sweep throttled");
      endcase
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule